// File: doc/BRIEF.md
# Cascadable Bit-Serial Configuration Memory

This block models a read-only serial memory that feeds configuration data to a loading device one bit at a time. It stores a parameterized number of bits. While it is selected and output-enabled, each rising edge of the incoming serial clock moves an internal address pointer forward and presents the next stored bit on a shared data line. The same pin does two jobs, reset and output enable, and a parameter sets which level of that pin means reset.

Several copies can be chained so that one data line carries more bits than one device holds. When a device has sent its last bit, it stops driving the data line and pulls its cascade-enable output low. That output drives the active-low chip enable of the next device in the chain, which then starts driving the line from its own address zero. A device that has run out stays in that state until it is reset, however many clocks arrive. The contents come from a seed parameter through a fixed formula, so a simulation can predict every bit. Capacity in real use is tens of thousands of bits (32K, 64K, 128K). The default here is kept small.

Top module: `serial_cfg_rom`

## Requirements
- R1: The power-on reset `rst` (synchronous, active high) clears the address pointer and the exhausted state. After it is released, `ce_out_n` is 1, and once `ce_in_n` is low the bit at address 0 is driven.
- R2: While selected (`ce_in_n` low, reset pin not asserting reset, not exhausted), each rising clock edge advances the pointer by one. The bit at the new address appears on `sdata` after that edge.
- R3: While `ce_in_n` is high, `sdata_drv` is 0 and the pointer holds. When the device is selected again, it resumes at the same bit.
- R4: With `RST_ACTIVE_HIGH`=1, `rst_oe`=1 means reset and `rst_oe`=0 means output enabled. With `RST_ACTIVE_HIGH`=0 the levels are swapped.
- R5: A clock edge that sees the reset level on `rst_oe` returns the pointer to 0 and clears the exhausted state. Reading then restarts from address 0.
- R6: While `rst_oe` is at its reset level, the output is disabled and `sdata_drv` is 0.
- R7: On the edge after the last bit (address DEPTH-1) was presented, the device becomes exhausted: `sdata_drv` goes to 0 and `sdata` floats. `ce_out_n` is 0 exactly while the device is exhausted and `ce_in_n` is low.
- R8: Once exhausted, the device stays exhausted, with no drive and `ce_out_n` low, while clocks continue. Only a reset (`rst` or the `rst_oe` reset level) ends this state.
- R9: A downstream device whose `ce_in_n` is driven by the upstream `ce_out_n` drives the shared line from its own address 0 in the first cycle after the handoff.
- R10: The stored bit at address a equals the XOR of all 32 bits of ((a*7) XOR SEED), with the product taken mod 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the loading device; one bit per rising edge |
| rst | input | 1 | Power-on reset, synchronous, active high |
| ce_in_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined reset / output-enable pin, polarity set by `RST_ACTIVE_HIGH` |
| sdata | output | 1 | Serial data, high impedance when not driving |
| sdata_drv | output | 1 | High while `sdata` is actively driven |
| ce_out_n | output | 1 | Cascade enable to the next device, active low |

## Verification
The hardest state to reach from the ports is the handoff between two chained devices. The upstream device must be walked through every stored bit, and the change of driver must then be seen in the very cycle it happens. The bench chains two instances with opposite reset polarities. It streams the first one to its end while tracking the expected address and checks on the handoff edge that the second device puts its address-0 bit on the merged line. It then keeps clocking to show that the exhausted state holds, toggles the upstream chip enable to show `ce_out_n` follows it, and re-arms the upstream device through its reset pin.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  // Content of the modelled memory: parity of (addr*7) xor seed.
  function automatic logic content_bit(input logic [31:0] addr,
                                       input logic [31:0] seed);
    logic [31:0] mixed;
    mixed = (addr * 32'd7) ^ seed;
    return ^mixed;
  endfunction

endpackage

// File: rtl/scfg_pin_decode.sv
module scfg_pin_decode #(
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic pin,
  output logic pin_rst,
  output logic oe_on
);

  generate
    if (RST_ACTIVE_HIGH) begin : g_rst_high
      assign pin_rst = pin;
      assign oe_on   = ~pin;
    end else begin : g_rst_low
      assign pin_rst = ~pin;
      assign oe_on   = pin;
    end
  endgenerate

endmodule

// File: rtl/scfg_addr_seq.sv
module scfg_addr_seq #(
  parameter int DEPTH = 2048,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_rst,
  input  logic          sel_n,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] rd_addr,
  output logic          exh
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic clr;
  logic adv;

  assign clr = rst | pin_rst;
  assign adv = ~sel_n & ~exh;

  // Address presented to the store so its registered output tracks ptr.
  always_comb begin
    if (clr)
      rd_addr = '0;
    else if (adv && (ptr != LAST))
      rd_addr = ptr + AW'(1);
    else
      rd_addr = ptr;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      ptr <= '0;
      exh <= 1'b0;
    end else if (adv) begin
      if (ptr == LAST)
        exh <= 1'b1;
      else
        ptr <= ptr + AW'(1);
    end
  end

endmodule

// File: rtl/scfg_bit_store.sv
module scfg_bit_store #(
  parameter int          DEPTH = 2048,
  parameter logic [31:0] SEED  = 32'h0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic          bit_q
);

  logic mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = scfg_pkg::content_bit(32'(i), SEED);
  end

  // Registered read, one bit wide, suits block RAM inference.
  always_ff @(posedge clk) begin
    bit_q <= mem[rd_addr];
  end

endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom #(
  parameter int          DEPTH           = 2048,
  parameter logic [31:0] SEED            = 32'h5A17_C3E9,
  parameter bit          RST_ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_in_n,
  input  logic rst_oe,
  output logic sdata,
  output logic sdata_drv,
  output logic ce_out_n
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          pin_rst;
  logic          oe_on;
  logic [AW-1:0] ptr;
  logic [AW-1:0] rd_addr;
  logic          exh;
  logic          bit_q;

  scfg_pin_decode #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_pin (
    .pin     (rst_oe),
    .pin_rst (pin_rst),
    .oe_on   (oe_on)
  );

  scfg_addr_seq #(.DEPTH(DEPTH)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .pin_rst (pin_rst),
    .sel_n   (ce_in_n),
    .ptr     (ptr),
    .rd_addr (rd_addr),
    .exh     (exh)
  );

  scfg_bit_store #(.DEPTH(DEPTH), .SEED(SEED)) u_store (
    .clk     (clk),
    .rd_addr (rd_addr),
    .bit_q   (bit_q)
  );

  assign sdata_drv = ~ce_in_n & oe_on & ~exh;
  assign sdata     = sdata_drv ? bit_q : 1'bz;
  assign ce_out_n  = ~(exh & ~ce_in_n);

endmodule

// File: rtl/scfg_chk.sv
module scfg_chk #(
  parameter int DEPTH           = 2048,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_in_n,
  input logic          rst_oe,
  input logic [AW-1:0] ptr,
  input logic          exh,
  input logic          sdata_drv,
  input logic          ce_out_n
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic rst_lvl;
  assign rst_lvl = (rst_oe == RST_ACTIVE_HIGH);

  // R1
  por_clear_chk: assert property (@(posedge clk)
    rst |=> (ptr == '0) && !exh);

  // R5
  pin_reset_chk: assert property (@(posedge clk) disable iff (rst)
    rst_lvl |=> (ptr == '0) && !exh);

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_in_n && !rst_lvl && !exh && ptr != LAST) |=> ptr == $past(ptr) + AW'(1));

  // R3
  hold_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_in_n && !rst_lvl) |=> $stable(ptr));

  // R3
  drv_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    sdata_drv |-> !ce_in_n);

  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    rst_lvl |-> !sdata_drv);

  // R7
  handoff_float_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_out_n |-> (!sdata_drv && exh));

  // R8
  exhaust_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (exh && !rst_lvl) |=> exh);

endmodule

bind serial_cfg_rom scfg_chk #(
  .DEPTH(DEPTH),
  .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce_in_n   (ce_in_n),
  .rst_oe    (rst_oe),
  .ptr       (ptr),
  .exh       (exh),
  .sdata_drv (sdata_drv),
  .ce_out_n  (ce_out_n)
);

// File: tb/tb_serial_cfg_rom.sv
module tb_serial_cfg_rom;

  localparam int          D1 = 40;
  localparam int          D2 = 24;
  localparam logic [31:0] S1 = 32'h1234_5678;
  localparam logic [31:0] S2 = 32'hCAFE_0F0F;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, ce_n, pin1, pin2;
  wire  sd1, sd2;
  logic drv1, drv2, co1, co2;
  logic line;

  int nchk  = 0;
  int nfail = 0;
  int e1    = 0;
  int e2    = 0;

  serial_cfg_rom #(.DEPTH(D1), .SEED(S1), .RST_ACTIVE_HIGH(1'b1)) dut (
    .clk(clk), .rst(rst), .ce_in_n(ce_n), .rst_oe(pin1),
    .sdata(sd1), .sdata_drv(drv1), .ce_out_n(co1));

  serial_cfg_rom #(.DEPTH(D2), .SEED(S2), .RST_ACTIVE_HIGH(1'b0)) dut2 (
    .clk(clk), .rst(rst), .ce_in_n(co1), .rst_oe(pin2),
    .sdata(sd2), .sdata_drv(drv2), .ce_out_n(co2));

  // Shared line with a pull-up when nobody drives.
  assign line = drv1 ? sd1 : (drv2 ? sd2 : 1'b1);

  function automatic logic ebit(input int a, input logic [31:0] s);
    logic [31:0] m;
    m = (32'(a) * 32'd7) ^ s;
    return ^m;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic t_por();
    rst = 1'b1; ce_n = 1'b1; pin1 = 1'b0; pin2 = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 drv1 after por", drv1, 1'b0);
    chk("R1 ce_out_n after por", co1, 1'b1);
    chk("R1 drv2 idle", drv2, 1'b0);
    ce_n = 1'b0; #1;
    e1 = 0;
    chk("R1 drv1 selected", drv1, 1'b1);
    chk("R1 bit0", sd1, ebit(0, S1));
  endtask

  task automatic t_stream(input int n);
    for (int k = 0; k < n; k++) begin
      tick();
      e1++;
      chk("R2 drv1 streaming", drv1, 1'b1);
      chk("R10 dut bit", sd1, ebit(e1, S1));
      chk("R2 line", line, ebit(e1, S1));
    end
  endtask

  task automatic t_deselect();
    ce_n = 1'b1; #1;
    chk("R3 drv1 deselected", drv1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R3 drv1 stays off", drv1, 1'b0);
      chk("R3 ce_out_n high", co1, 1'b1);
    end
    ce_n = 1'b0; #1;
    chk("R3 resume drv", drv1, 1'b1);
    chk("R3 resume same bit", sd1, ebit(e1, S1));
  endtask

  task automatic t_pin1_reset();
    pin1 = 1'b1; #1;
    chk("R6 drv1 off at reset level", drv1, 1'b0);
    tick();
    chk("R6 drv1 still off", drv1, 1'b0);
    pin1 = 1'b0; #1;
    e1 = 0;
    chk("R4 high level reset, enabled low", drv1, 1'b1);
    chk("R5 restart bit0", sd1, ebit(0, S1));
  endtask

  task automatic t_exhaust();
    while (e1 < D1 - 1) begin
      tick();
      e1++;
      chk("R2 bit to end", sd1, ebit(e1, S1));
    end
    tick();
    chk("R7 drv1 floats", drv1, 1'b0);
    chk("R7 ce_out_n low", co1, 1'b0);
    e2 = 0;
    chk("R9 dut2 takes over", drv2, 1'b1);
    chk("R9 dut2 bit0 on line", line, ebit(0, S2));
    for (int k = 0; k < 3; k++) begin
      tick();
      e2++;
      chk("R8 drv1 stays off", drv1, 1'b0);
      chk("R8 ce_out_n stays low", co1, 1'b0);
      chk("R9 dut2 stream", line, ebit(e2, S2));
    end
  endtask

  task automatic t_pol2();
    pin2 = 1'b0; #1;
    chk("R4 low level resets dut2", drv2, 1'b0);
    tick();
    pin2 = 1'b1; #1;
    e2 = 0;
    chk("R4 dut2 enabled high", drv2, 1'b1);
    chk("R5 dut2 bit0", sd2, ebit(0, S2));
    tick();
    e2++;
    chk("R2 dut2 next bit", sd2, ebit(e2, S2));
  endtask

  task automatic t_ce_exhausted();
    ce_n = 1'b1; #1;
    chk("R7 ce_out_n follows ce_in_n", co1, 1'b1);
    chk("R7 dut2 released", drv2, 1'b0);
    ce_n = 1'b0; #1;
    chk("R7 ce_out_n low again", co1, 1'b0);
    chk("R7 dut2 drives again", drv2, 1'b1);
  endtask

  task automatic t_rearm();
    pin1 = 1'b1;
    tick();
    pin1 = 1'b0; #1;
    e1 = 0;
    chk("R8 rearm ce_out_n", co1, 1'b1);
    chk("R8 rearm drv1", drv1, 1'b1);
    chk("R8 rearm bit0", sd1, ebit(0, S1));
    chk("R8 dut2 off after rearm", drv2, 1'b0);
    tick();
    e1++;
    chk("R2 after rearm", sd1, ebit(e1, S1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    t_por();
    t_stream(10);
    t_deselect();
    t_stream(5);
    t_pin1_reset();
    t_exhaust();
    t_pol2();
    t_ce_exhausted();
    t_rearm();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule